// File: doc/BRIEF.md
# Quadword Byte-Lane Access Splitter

This block sits between a CPU-side load/store port and a bus cycle sequencer that moves 64-bit quadwords. Each CPU access has a 32-bit byte address, a size code, a read/write flag and a memory/IO space select. The block turns it into one or two bus requests. Each bus request carries a quadword address, which is the byte address with its three low bits dropped, and eight active-low lane enables, one per byte of the data bus.

Alignment is soft. If the bytes of an access all fall inside one quadword, the block issues a single request. If they run past the end of a quadword, it issues two requests, the lower quadword first. Write data is moved onto the lanes its bytes occupy. Read data from one or both bus responses is gathered back into a right-justified result, and a single completion is returned to the CPU side.

Both request paths use valid/ready handshakes. Once the CPU side sees `cpu_req_ready` high and drives `cpu_req_valid`, the access is taken in that cycle. `cpu_req_ready` then stays low until the completion has been accepted. A bus request holds its address, enables and data stable while `bus_req_ready` is low. The completion holds stable while `cpu_rsp_ready` is low. `bus_rsp_valid` is a plain acknowledge pulse. It carries no back-pressure, and one pulse is expected per request after that request has been accepted.

Top module: `qw_access_splitter`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, and both `bus_req_valid` and `cpu_rsp_valid` are 0.
- R2: The size code gives the byte count: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. With offset o = address bits 2..0, bit i of `bus_be_n` is 0 exactly when lane i holds a byte of the access.
- R3: For memory accesses, the first request's `bus_addr` equals address bits 31..3.
- R4: When o plus the byte count exceeds 8, two requests are issued. The first covers lanes o..7 of the lower quadword. The second uses quadword address + 1 (modulo the address space) and covers lanes 0 upward.
- R5: When the access fits inside one quadword, exactly one request is issued.
- R6: On a write, byte k of `cpu_wdata` (k below the byte count) appears on lane (address + k) mod 8 of the request that holds byte address + k. Disabled lanes carry zero. Bytes of `cpu_wdata` at or above the byte count are not used.
- R7: On a read, byte k of `cpu_rdata` is the byte returned for address + k. Bytes at or above the byte count read as zero. One completion is given per access.
- R8: `bus_is_mem` and `bus_write` follow the access. For IO accesses (`cpu_is_mem` = 0), bits 28..13 of `bus_addr` are zero, so the IO quadword address wraps within 16 address bits.
- R9: A bus request holds stable while it waits for `bus_req_ready`. `cpu_req_ready` stays 0 from acceptance until the completion handshake, and is 1 again on the next cycle.
- R10: `cpu_rsp_valid` and `cpu_rdata` hold stable until `cpu_rsp_ready` is seen.
- R11: A `bus_rsp_valid` pulse that arrives while no accepted request is waiting for a response is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU access offered |
| cpu_req_ready | output | 1 | Splitter can take an access |
| cpu_addr | input | 32 | Byte address |
| cpu_size | input | 2 | Size code (0 byte, 1 word, 2 dword, 3 qword) |
| cpu_write | input | 1 | 1 for write |
| cpu_is_mem | input | 1 | 1 memory space, 0 IO space |
| cpu_wdata | input | 64 | Right-justified write data |
| cpu_rsp_valid | output | 1 | Access completed |
| cpu_rsp_ready | input | 1 | CPU side takes completion |
| cpu_rdata | output | 64 | Right-justified, merged read data |
| bus_req_valid | output | 1 | Bus request offered |
| bus_req_ready | input | 1 | Sequencer takes request |
| bus_addr | output | 29 | Quadword address |
| bus_be_n | output | 8 | Active-low lane enables |
| bus_write | output | 1 | Request is a write |
| bus_is_mem | output | 1 | Request space select |
| bus_wdata | output | 64 | Lane-placed write data |
| bus_rsp_valid | input | 1 | Acknowledge of the accepted request |
| bus_rdata | input | 64 | Read data with the acknowledge |

## Verification
A wrong lane decode shows up on `bus_be_n` in the first cycle of the request. A wrong split decision shows up as a missing or extra second request, one cycle after the first acknowledge. A phase register that is stale or set wrongly either repeats the lower quadword address or puts the enables of the other half on the bus. Read-merge faults appear only at the completion, as misplaced or non-zero bytes in `cpu_rdata`. The vectors therefore cover every offset class at each boundary, including address wrap in both spaces.

// File: rtl/qws_pkg.sv
package qws_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_RESP  = 2'd3
  } qws_state_e;
endpackage

// File: rtl/qws_lane_mask.sv
module qws_lane_mask #(
  parameter int LANES = 8,
  parameter int OFS_W = 3,
  parameter int SZ_W  = 2
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [SZ_W-1:0]  size,
  output logic [LANES-1:0] lo_mask,
  output logic [LANES-1:0] hi_mask,
  output logic             crosses
);
  logic [2*LANES-1:0] span;
  int nb;

  // lanes of the access laid across two consecutive quadwords
  always_comb begin
    nb = 1 << size;
    for (int i = 0; i < 2*LANES; i++)
      span[i] = (i >= int'(ofs)) && (i < int'(ofs) + nb);
  end

  assign lo_mask = span[LANES-1:0];
  assign hi_mask = span[2*LANES-1:LANES];
  assign crosses = |hi_mask;
endmodule

// File: rtl/qws_lane_shift.sv
module qws_lane_shift #(
  parameter int LANES = 8,
  parameter int OFS_W = 3,
  parameter int SZ_W  = 2
) (
  input  logic [OFS_W-1:0]     ofs,
  input  logic [SZ_W-1:0]      size,
  input  logic [8*LANES-1:0]   wdata,
  input  logic [16*LANES-1:0]  rbuf,
  output logic [16*LANES-1:0]  wide,
  output logic [8*LANES-1:0]   rdata
);
  int nb;

  always_comb begin
    nb    = 1 << size;
    wide  = '0;
    rdata = '0;
    // write: source byte k lands on double-quadword lane ofs+k
    for (int j = 0; j < 2*LANES; j++)
      if (j >= int'(ofs) && (j - int'(ofs)) < nb)
        wide[8*j +: 8] = wdata[8*(j - int'(ofs)) +: 8];
    // read: gather from lane ofs+k back to byte k
    for (int k = 0; k < LANES; k++)
      if (k < nb)
        rdata[8*k +: 8] = rbuf[8*(k + int'(ofs)) +: 8];
  end
endmodule

// File: rtl/qw_access_splitter.sv
module qw_access_splitter
  import qws_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int IO_ADDR_W = 16,
  parameter int SZ_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req_valid,
  output logic                          cpu_req_ready,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [SZ_W-1:0]               cpu_size,
  input  logic                          cpu_write,
  input  logic                          cpu_is_mem,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic                          cpu_rsp_valid,
  input  logic                          cpu_rsp_ready,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          bus_req_valid,
  input  logic                          bus_req_ready,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] bus_addr,
  output logic [DATA_W/8-1:0]           bus_be_n,
  output logic                          bus_write,
  output logic                          bus_is_mem,
  output logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_rsp_valid,
  input  logic [DATA_W-1:0]             bus_rdata
);
  localparam int LANES   = DATA_W / 8;
  localparam int OFS_W   = $clog2(LANES);
  localparam int QA_W    = ADDR_W - OFS_W;
  localparam int IO_QA_W = IO_ADDR_W - OFS_W;
  localparam logic [QA_W-1:0] IO_MASK = {{(QA_W-IO_QA_W){1'b0}}, {IO_QA_W{1'b1}}};

  qws_state_e          st;
  logic                hi_phase;
  logic [QA_W-1:0]     a_base;
  logic [OFS_W-1:0]    a_ofs;
  logic [SZ_W-1:0]     a_size;
  logic                a_wr, a_mem;
  logic [DATA_W-1:0]   a_wdata;
  logic [2*DATA_W-1:0] rbuf;

  logic [LANES-1:0]    lo_mask, hi_mask;
  logic                crosses;
  logic [2*DATA_W-1:0] wide;
  logic [QA_W-1:0]     raw_qa;

  qws_lane_mask #(.LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_mask (
    .ofs(a_ofs), .size(a_size),
    .lo_mask(lo_mask), .hi_mask(hi_mask), .crosses(crosses)
  );

  qws_lane_shift #(.LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_shift (
    .ofs(a_ofs), .size(a_size), .wdata(a_wdata), .rbuf(rbuf),
    .wide(wide), .rdata(cpu_rdata)
  );

  // request fields
  assign raw_qa        = a_base + QA_W'(hi_phase);
  assign bus_addr      = a_mem ? raw_qa : (raw_qa & IO_MASK);
  assign bus_be_n      = ~(hi_phase ? hi_mask : lo_mask);
  assign bus_wdata     = hi_phase ? wide[2*DATA_W-1:DATA_W] : wide[DATA_W-1:0];
  assign bus_write     = a_wr;
  assign bus_is_mem    = a_mem;
  assign bus_req_valid = (st == S_ISSUE);
  assign cpu_req_ready = (st == S_IDLE);
  assign cpu_rsp_valid = (st == S_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hi_phase <= 1'b0;
      a_base   <= '0;
      a_ofs    <= '0;
      a_size   <= '0;
      a_wr     <= 1'b0;
      a_mem    <= 1'b0;
      a_wdata  <= '0;
      rbuf     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (cpu_req_valid) begin
          a_base   <= cpu_addr[ADDR_W-1:OFS_W];
          a_ofs    <= cpu_addr[OFS_W-1:0];
          a_size   <= cpu_size;
          a_wr     <= cpu_write;
          a_mem    <= cpu_is_mem;
          a_wdata  <= cpu_wdata;
          hi_phase <= 1'b0;
          st       <= S_ISSUE;
        end
        S_ISSUE: if (bus_req_ready) st <= S_WAIT;
        S_WAIT: if (bus_rsp_valid) begin
          if (hi_phase) begin
            rbuf[2*DATA_W-1:DATA_W] <= bus_rdata;
            st <= S_RESP;
          end else begin
            rbuf[DATA_W-1:0] <= bus_rdata;
            if (crosses) begin
              hi_phase <= 1'b1;
              st       <= S_ISSUE;
            end else begin
              st <= S_RESP;
            end
          end
        end
        S_RESP: if (cpu_rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: every request enables at least one lane
  p_be_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_be_n != {LANES{1'b1}});

  // R8: IO requests keep the quadword address inside the IO window
  p_io_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_is_mem) |-> (bus_addr & ~IO_MASK) == '0);

  // R9: a stalled request holds its fields
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wdata)));

  // R9: no new CPU access while a bus request is outstanding
  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready);

  // R10: completion holds until taken
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rdata)));

  // R4: the upper-half request never precedes an accepted lower-half request
  p_split_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) && $past(bus_rsp_valid) |-> bus_be_n[0] == 1'b0);
endmodule

// File: tb/qw_access_splitter_tb.sv
module qw_access_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_ready;
  logic [31:0] cpu_addr;
  logic [1:0]  cpu_size;
  logic        cpu_write, cpu_is_mem;
  logic [63:0] cpu_wdata;
  logic        cpu_rsp_valid, cpu_rsp_ready;
  logic [63:0] cpu_rdata;
  logic        bus_req_valid, bus_req_ready;
  logic [28:0] bus_addr;
  logic [7:0]  bus_be_n;
  logic        bus_write, bus_is_mem;
  logic [63:0] bus_wdata;
  logic        bus_rsp_valid;
  logic [63:0] bus_rdata;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  qw_access_splitter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_write(cpu_write),
    .cpu_is_mem(cpu_is_mem), .cpu_wdata(cpu_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rdata(cpu_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_write(bus_write),
    .bus_is_mem(bus_is_mem), .bus_wdata(bus_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic        wr;
    logic        mem;
    logic [1:0]  n;
    logic [7:0]  be0;
    logic [7:0]  be1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 2'd3, 1'b0, 1'b1, 2'd1, 8'h00, 8'hFF},
    '{32'h0000_1003, 2'd0, 1'b1, 1'b1, 2'd1, 8'hF7, 8'hFF},
    '{32'h0000_1006, 2'd1, 1'b1, 1'b1, 2'd1, 8'h3F, 8'hFF},
    '{32'h0000_1007, 2'd1, 1'b0, 1'b1, 2'd2, 8'h7F, 8'hFE},
    '{32'h0000_2005, 2'd2, 1'b1, 1'b1, 2'd2, 8'h1F, 8'hFE},
    '{32'h0000_2004, 2'd2, 1'b0, 1'b1, 2'd1, 8'h0F, 8'hFF},
    '{32'h0000_3001, 2'd3, 1'b0, 1'b1, 2'd2, 8'h01, 8'hFE},
    '{32'h0000_3001, 2'd3, 1'b1, 1'b1, 2'd2, 8'h01, 8'hFE},
    '{32'hABCD_0102, 2'd1, 1'b0, 1'b0, 2'd1, 8'hF3, 8'hFF},
    '{32'h0000_FFFE, 2'd2, 1'b1, 1'b0, 2'd2, 8'h3F, 8'hFC},
    '{32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 2'd1, 8'h7F, 8'hFF},
    '{32'hFFFF_FFFC, 2'd3, 1'b1, 1'b1, 2'd2, 8'h0F, 8'hF0}
  };

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [28:0] q);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) r[8*l +: 8] = {q[4:0], 3'(l)};
    return r;
  endfunction

  function automatic logic [28:0] qmap(input logic [31:0] a, input logic mem);
    return mem ? a[31:3] : (a[31:3] & 29'h1FFF);
  endfunction

  task automatic run_access(input vec_t v, input logic [63:0] wd, input int stall,
                            input logic junk, input logic hold_rsp);
    logic [28:0] g_addr [2];
    logic [7:0]  g_be   [2];
    logic [63:0] g_wd   [2];
    logic        g_wr   [2];
    logic        g_mem  [2];
    logic [63:0] exp_rd, rd0;
    logic [31:0] ab;
    logic [28:0] q0, q1;
    int n = 0;
    logic done = 1'b0;
    int nb;
    nb = 1 << v.sz;
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R9 ready before access", 64'(cpu_req_ready), 64'd1);
    cpu_req_valid = 1'b1; cpu_addr = v.a; cpu_size = v.sz;
    cpu_write = v.wr; cpu_is_mem = v.mem; cpu_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int guard = 0; guard < 60 && !done; guard++) begin
      if (bus_req_valid) begin
        check(cpu_req_ready == 1'b0, "R9 busy while request out", 64'(cpu_req_ready), 64'd0);
        if (n < 2) begin
          g_addr[n] = bus_addr; g_be[n] = bus_be_n; g_wd[n] = bus_wdata;
          g_wr[n] = bus_write; g_mem[n] = bus_is_mem;
        end
        for (int s = 0; s < stall; s++) begin
          bus_rsp_valid = junk; bus_rdata = 64'hDEAD_BEEF_0BAD_F00D;
          @(negedge clk);
          bus_rsp_valid = 1'b0;
          if (n < 2)
            check(bus_req_valid && bus_addr == g_addr[n] && bus_be_n == g_be[n] && bus_wdata == g_wd[n],
                  "R9/R11 request held while stalled", {35'd0, bus_addr}, {35'd0, g_addr[n]});
        end
        bus_req_ready = 1'b1;
        @(negedge clk);
        bus_req_ready = 1'b0;
        bus_rsp_valid = 1'b1;
        bus_rdata = pat(bus_addr);
        @(negedge clk);
        bus_rsp_valid = 1'b0;
        n++;
      end else if (cpu_rsp_valid) begin
        done = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    check(done, "R7 completion seen", 64'(done), 64'd1);
    check(n == int'(v.n), "R4/R5 request count", 64'(n), 64'(v.n));
    q0 = qmap(v.a, v.mem);
    q1 = v.mem ? (v.a[31:3] + 29'd1) : ((v.a[31:3] + 29'd1) & 29'h1FFF);
    if (n >= 1) begin
      check(g_be[0] == v.be0, "R2 lower enables", 64'(g_be[0]), 64'(v.be0));
      check(g_addr[0] == q0, "R3/R8 first address", 64'(g_addr[0]), 64'(q0));
      check(g_mem[0] == v.mem && g_wr[0] == v.wr, "R8 space and direction",
            {62'd0, g_mem[0], g_wr[0]}, {62'd0, v.mem, v.wr});
    end
    if (n == 2) begin
      check(g_be[1] == v.be1, "R4 upper enables", 64'(g_be[1]), 64'(v.be1));
      check(g_addr[1] == q1, "R4 second address", 64'(g_addr[1]), 64'(q1));
    end
    if (v.wr && n >= 1 && n <= 2) begin
      logic [63:0] ew [2];
      ew[0] = '0; ew[1] = '0;
      for (int k = 0; k < nb; k++) begin
        ab = v.a + 32'(k);
        if (ab[31:3] == v.a[31:3]) ew[0][8*ab[2:0] +: 8] = wd[8*k +: 8];
        else                       ew[1][8*ab[2:0] +: 8] = wd[8*k +: 8];
      end
      for (int r = 0; r < n; r++)
        check(g_wd[r] == ew[r], "R6 write lanes", g_wd[r], ew[r]);
    end
    if (!v.wr && done) begin
      exp_rd = '0;
      for (int k = 0; k < nb; k++) begin
        ab = v.a + 32'(k);
        exp_rd[8*k +: 8] = {qmap(ab, v.mem) & 29'h1F, ab[2:0]} [7:0];
      end
      check(cpu_rdata == exp_rd, "R7 merged read", cpu_rdata, exp_rd);
    end
    if (hold_rsp && done) begin
      rd0 = cpu_rdata;
      repeat (2) @(negedge clk);
      check(cpu_rsp_valid && cpu_rdata == rd0, "R10 completion held", cpu_rdata, rd0);
    end
    cpu_rsp_ready = 1'b1;
    @(negedge clk);
    cpu_rsp_ready = 1'b0;
    check(!cpu_rsp_valid && cpu_req_ready, "R9 ready after completion",
          {62'd0, cpu_rsp_valid, cpu_req_ready}, 64'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_addr = '0; cpu_size = '0; cpu_write = 1'b0;
    cpu_is_mem = 1'b1; cpu_wdata = '0; cpu_rsp_ready = 1'b0;
    bus_req_ready = 1'b0; bus_rsp_valid = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cpu_req_ready && !bus_req_valid && !cpu_rsp_valid, "R1 reset state",
          {61'd0, cpu_req_ready, bus_req_valid, cpu_rsp_valid}, 64'h4);

    for (int i = 0; i < NV; i++)
      run_access(VECS[i], 64'h0123_4567_89AB_CDEF ^ {8{8'(i * 17)}}, i % 3, 1'b0, i[0]);

    // R11: stray acknowledge while idle, then a split read must still merge correctly
    @(negedge clk);
    bus_rsp_valid = 1'b1; bus_rdata = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
    check(cpu_req_ready && !cpu_rsp_valid && !bus_req_valid, "R11 idle acknowledge ignored",
          {61'd0, cpu_req_ready, cpu_rsp_valid, bus_req_valid}, 64'h4);
    run_access(VECS[3], 64'd0, 0, 1'b0, 1'b0);

    // R11: stray acknowledges while the request is stalled
    run_access(VECS[6], 64'd0, 3, 1'b1, 1'b1);
    run_access(VECS[9], 64'hA5A5_5A5A_1234_5678, 2, 1'b1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule